// File: doc/BRIEF.md
# GPIO and Pin-Multiplexer Register Bank

This block is a byte-wide register file for up to 48 general-purpose pins. For each pin it holds a function-select bit, a direction bit, an output latch and a pull-down enable. It also returns a synchronized sample of the pad input. Pins are numbered from 1. Pin n lives in byte (n-1)/8 of each register group, at bit (n-1)%8. One shared alternate-function byte refines the mode of pins that have more than one alternate use.

A per-pin table, given as parameters, lists each pin's one or two positions inside the shared byte, its alt A and alt B codes, and the mode that counts as GPIO for that pin. From the select bit and these positions the block decodes each pin's mode. It drives the pad output-enable and pad data, and it reports each pin's mode code and its effective level. A host reads and writes the bank over a simple synchronous byte port: writes take effect on the clock edge and reads are combinational.

Top module: `gpio_mux_bank`

## Requirements
- R1: After reset every pin is an input, with select 0, output latch 0, pull-down enabled (pull bytes read 0xFF) and the shared alternate byte 0. No pad output-enable is asserted.
- R2: Register groups start at 0x00 (select), 0x10 (direction), 0x20 (output latch) and 0x30 (pull-down). Each group has one byte per eight pins. A write to one of these groups is read back unchanged, and pin n maps to byte (n-1)/8, bit (n-1)%8.
- R3: Writing the direction group with a bit at 1 makes that pin an output and clears the pin's pull-down bit in the same cycle. Bits written as 0 leave the pull-down bits alone.
- R4: Reads at 0x40 onward return the pad inputs through a two-flop synchronizer. A pad change is visible after the second rising clock edge, and writes to this group change nothing.
- R5: The shared alternate byte is at 0x50. Every other address (for example 0x06, 0x46, 0x51, 0x60) reads as 0, and writes to such addresses change no register.
- R6: A pin's level output equals its output latch when its direction bit is 1, and its synchronized input otherwise.
- R7: Mode codes are 0 = default, 1 = alt A, 2 = alt B, 3 = alt C. For a pin with no alternate positions, select 0 gives default and select 1 gives alt A.
- R8: For a pin with at least one alternate position, select 1 gives default. With select 0, a two-bit code is formed as {second position bit, first position bit}; an unused second position counts as 0. A code equal to the pin's alt A code gives alt A, otherwise a code equal to its alt B code gives alt B, and any other code gives alt C.
- R9: A pad output-enable is 1 exactly when the pin's direction bit is 1 and its decoded mode equals its GPIO mode. Pad data is always the output latch.
- R10: The configuration error output is 1 when any pin has a position above 7 that is not the unused marker (15), or uses a second position without a first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| we | input | 1 | Write strobe for the current address |
| addr | input | 8 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| pad_in | input | NUM_PINS | Asynchronous pad input levels |
| pad_oe | output | NUM_PINS | Pad output-enable |
| pad_out | output | NUM_PINS | Pad output data |
| pin_level | output | NUM_PINS | Effective level of each pin |
| pin_mode | output | 2*NUM_PINS | Decoded mode code per pin, two bits each |
| cfg_err | output | 1 | Per-pin table violates the position rules |

## Verification
The properties assume at most one host write per cycle, so the direction write and its pull-down clearing are never hidden by a pull write in the same cycle. They also assume the pad inputs stay quiet during reset, so the synchronizer check only has to compare against samples taken after reset. The stimulus drives every input on the falling clock edge and writes one byte per transaction. It holds pad_in at zero until reset ends and changes a single pad bit at a time, so the two-edge delay can be observed cycle by cycle.

// File: rtl/gpio_mux_bank.sv
module gpio_mux_bank #(
  parameter int NUM_PINS = 48,
  parameter logic [4*NUM_PINS-1:0] ALT1_POS  = {{44{4'hF}}, 4'd3, 4'd2, 4'd0, 4'hF},
  parameter logic [4*NUM_PINS-1:0] ALT2_POS  = {{44{4'hF}}, 4'd4, 4'hF, 4'd1, 4'hF},
  parameter logic [2*NUM_PINS-1:0] ALTA_CODE = {{44{2'd0}}, 2'd2, 2'd1, 2'd0, 2'd0},
  parameter logic [2*NUM_PINS-1:0] ALTB_CODE = {{44{2'd0}}, 2'd3, 2'd0, 2'd1, 2'd0},
  parameter logic [2*NUM_PINS-1:0] GPIO_MODE = {{44{2'd0}}, 2'd0, 2'd1, 2'd0, 2'd0}
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [7:0]            addr,
  input  logic [7:0]            wdata,
  output logic [7:0]            rdata,
  input  logic [NUM_PINS-1:0]   pad_in,
  output logic [NUM_PINS-1:0]   pad_oe,
  output logic [NUM_PINS-1:0]   pad_out,
  output logic [NUM_PINS-1:0]   pin_level,
  output logic [2*NUM_PINS-1:0] pin_mode,
  output logic                  cfg_err
);
  localparam int NBYTES = (NUM_PINS + 7) / 8;
  localparam int NBITS  = NBYTES * 8;
  localparam logic [3:0] UNUSED = 4'hF;
  localparam logic [1:0] M_DEF = 2'd0, M_A = 2'd1, M_B = 2'd2, M_C = 2'd3;

  function automatic logic [NBITS-1:0] pin_mask();
    logic [NBITS-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_PINS; i++) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic table_bad();
    logic bad;
    logic [3:0] p1, p2;
    bad = 1'b0;
    for (int i = 0; i < NUM_PINS; i++) begin
      p1 = ALT1_POS[4*i +: 4];
      p2 = ALT2_POS[4*i +: 4];
      if ((p1 > 4'd7 && p1 != UNUSED) || (p2 > 4'd7 && p2 != UNUSED) ||
          (p2 != UNUSED && p1 == UNUSED))
        bad = 1'b1;
    end
    return bad;
  endfunction

  localparam logic [NBITS-1:0] MASK = pin_mask();
  localparam logic CFG_BAD = table_bad();

  logic [NBITS-1:0]    sel_q, dir_q, out_q, pull_q;
  logic [7:0]          alt_q;
  logic [NUM_PINS-1:0] sync1_q, in_q;
  logic [NBITS-1:0]    in_ext;

  logic [3:0] grp, bidx;
  logic       byte_ok;
  int         boff;

  assign grp     = addr[7:4];
  assign bidx    = addr[3:0];
  assign byte_ok = 32'(bidx) < NBYTES;
  assign boff    = 32'(bidx) * 8;
  assign in_ext  = NBITS'(in_q);
  assign cfg_err = CFG_BAD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      in_q    <= '0;
    end else begin
      sync1_q <= pad_in;
      in_q    <= sync1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      dir_q  <= '0;
      out_q  <= '0;
      pull_q <= MASK;
      alt_q  <= '0;
    end else if (we) begin
      if (byte_ok) begin
        case (grp)
          4'h0: sel_q[boff +: 8] <= wdata & MASK[boff +: 8];
          4'h1: begin
            dir_q[boff +: 8]  <= wdata & MASK[boff +: 8];
            pull_q[boff +: 8] <= pull_q[boff +: 8] & ~wdata;
          end
          4'h2: out_q[boff +: 8]  <= wdata & MASK[boff +: 8];
          4'h3: pull_q[boff +: 8] <= wdata & MASK[boff +: 8];
          default: ;
        endcase
      end
      if (addr == 8'h50) alt_q <= wdata;
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (byte_ok) begin
      case (grp)
        4'h0: rdata = sel_q[boff +: 8];
        4'h1: rdata = dir_q[boff +: 8];
        4'h2: rdata = out_q[boff +: 8];
        4'h3: rdata = pull_q[boff +: 8];
        4'h4: rdata = in_ext[boff +: 8];
        default: ;
      endcase
    end
    if (addr == 8'h50) rdata = alt_q;
  end

  assign pad_out = out_q[NUM_PINS-1:0];

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    localparam logic [3:0] P1 = ALT1_POS[4*i +: 4];
    localparam logic [3:0] P2 = ALT2_POS[4*i +: 4];
    localparam logic [1:0] AC = ALTA_CODE[2*i +: 2];
    localparam logic [1:0] BC = ALTB_CODE[2*i +: 2];
    localparam logic [1:0] GM = GPIO_MODE[2*i +: 2];
    logic [1:0] mode;
    if (P1 == UNUSED) begin : g_plain
      assign mode = sel_q[i] ? M_A : M_DEF;
    end else begin : g_alt
      logic [1:0] code;
      assign code = {(P2 == UNUSED) ? 1'b0 : alt_q[P2[2:0]], alt_q[P1[2:0]]};
      assign mode = sel_q[i]   ? M_DEF :
                    code == AC ? M_A   :
                    code == BC ? M_B   : M_C;
    end
    assign pin_mode[2*i +: 2] = mode;
    assign pad_oe[i]    = dir_q[i] && (mode == GM);
    assign pin_level[i] = dir_q[i] ? out_q[i] : in_q[i];
  end
endmodule

module gpio_mux_bank_chk #(
  parameter int NUM_PINS = 48,
  parameter logic [4*NUM_PINS-1:0] ALT1_POS = '1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  we,
  input logic [7:0]            addr,
  input logic [7:0]            wdata,
  input logic [7:0]            rdata,
  input logic [NUM_PINS-1:0]   pad_in,
  input logic [NUM_PINS-1:0]   pad_oe,
  input logic [NUM_PINS-1:0]   pad_out,
  input logic [NUM_PINS-1:0]   pin_level,
  input logic [2*NUM_PINS-1:0] pin_mode,
  input logic [((NUM_PINS+7)/8)*8-1:0] pull_q,
  input logic [NUM_PINS-1:0]   in_q
);
  localparam int NB = (NUM_PINS + 7) / 8;

  logic       prev_dirwr;
  logic [7:0] prev_wd;
  int         prev_off;
  logic [1:0] settle;
  logic       unmapped;

  assign unmapped = !((addr[7:4] <= 4'h4) && (32'(addr[3:0]) < NB)) && (addr != 8'h50);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_dirwr <= 1'b0;
      prev_wd    <= '0;
      prev_off   <= 0;
      settle     <= '0;
    end else begin
      prev_dirwr <= we && addr[7:4] == 4'h1 && 32'(addr[3:0]) < NB;
      prev_wd    <= wdata;
      prev_off   <= 32'(addr[3:0]) * 8;
      if (settle != 2'd3) settle <= settle + 2'd1;
    end
  end

  assert_reset_no_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> pad_oe == '0);

  assert_dir_clears_pull_R3: assert property (@(posedge clk) disable iff (!rst_n)
    prev_dirwr |-> (pull_q[prev_off +: 8] & prev_wd) == 8'h00);

  assert_two_flop_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    settle >= 2'd2 |-> in_q == $past(pad_in, 2));

  assert_unmapped_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> rdata == 8'h00);

  assert_oe_follows_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & (pin_level ^ pad_out)) == '0);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_plain_chk
    if (ALT1_POS[4*i +: 4] == 4'hF) begin : g_on
      assert_plain_modes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pin_mode[2*i +: 2] <= 2'd1);
    end
  end
endmodule

bind gpio_mux_bank gpio_mux_bank_chk #(.NUM_PINS(NUM_PINS), .ALT1_POS(ALT1_POS)) u_chk (.*);

// File: tb/gpio_mux_bank_bench.sv
module gpio_mux_bank_bench;
  localparam int N = 48;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         we = 1'b0;
  logic [7:0]   addr = '0;
  logic [7:0]   wdata = '0;
  logic [7:0]   rdata;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] pad_oe, pad_out, pin_level;
  logic [2*N-1:0] pin_mode;
  logic         cfg_err;

  logic [7:0] rd_a, rd_b;
  logic [7:0] oe_a, oe_b, po_a, po_b, lv_a, lv_b;
  logic [15:0] pm_a, pm_b;
  logic ce_a, ce_b;

  always #4 clk = ~clk;

  gpio_mux_bank u_gpio_mux_bank (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata), .rdata(rdata),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pin_level(pin_level),
    .pin_mode(pin_mode), .cfg_err(cfg_err));

  gpio_mux_bank #(.NUM_PINS(8), .ALT1_POS({8{4'hF}}), .ALT2_POS({{7{4'hF}}, 4'd1}),
    .ALTA_CODE('0), .ALTB_CODE('0), .GPIO_MODE('0)) u_bad_a (
    .clk(clk), .rst_n(rst_n), .we(1'b0), .addr(8'h00), .wdata(8'h00), .rdata(rd_a),
    .pad_in(8'h00), .pad_oe(oe_a), .pad_out(po_a), .pin_level(lv_a),
    .pin_mode(pm_a), .cfg_err(ce_a));

  gpio_mux_bank #(.NUM_PINS(8), .ALT1_POS({{7{4'hF}}, 4'd9}), .ALT2_POS({8{4'hF}}),
    .ALTA_CODE('0), .ALTB_CODE('0), .GPIO_MODE('0)) u_bad_b (
    .clk(clk), .rst_n(rst_n), .we(1'b0), .addr(8'h00), .wdata(8'h00), .rdata(rd_b),
    .pad_in(8'h00), .pad_oe(oe_b), .pad_out(po_b), .pin_level(lv_b),
    .pin_mode(pm_b), .cfg_err(ce_b));

  typedef struct {
    int         kind;
    int         idx;
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  localparam int K_RD = 0, K_MODE = 1, K_LVL = 2, K_OE = 3, K_OUT = 4,
                 K_ERRA = 5, K_ERRB = 6, K_ERR = 7;

  initial forever begin
    @(negedge clk);
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      case (it.kind)
        K_RD:    act = rdata;
        K_MODE:  act = {6'd0, pin_mode[2*it.idx +: 2]};
        K_LVL:   act = {7'd0, pin_level[it.idx]};
        K_OE:    act = {7'd0, pad_oe[it.idx]};
        K_OUT:   act = {7'd0, pad_out[it.idx]};
        K_ERRA:  act = {7'd0, ce_a};
        K_ERRB:  act = {7'd0, ce_b};
        default: act = {7'd0, cfg_err};
      endcase
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s kind %0d idx %0d: actual %0h expected %0h",
                 it.req, it.kind, it.idx, act, it.exp);
      end
    end
  end

  task automatic push(input int kind, input int idx, input logic [7:0] exp, input string req);
    item_t it;
    it.kind = kind; it.idx = idx; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  task automatic chk(input int kind, input int idx, input logic [7:0] exp, input string req);
    @(negedge clk);
    we = 1'b0;
    if (kind == K_RD) addr = idx[7:0];
    push(kind, idx, exp, req);
    @(posedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1;
    we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int b = 0; b < 6; b++) begin
      chk(K_RD, 8'h00 + b, 8'h00, "R1 select reset");
      chk(K_RD, 8'h10 + b, 8'h00, "R1 direction reset");
      chk(K_RD, 8'h20 + b, 8'h00, "R1 output reset");
      chk(K_RD, 8'h30 + b, 8'hFF, "R1 pull reset");
    end
    chk(K_RD, 8'h50, 8'h00, "R1 alt byte reset");
    chk(K_OE, 0, 8'h0, "R1 no oe");
    chk(K_OE, 47, 8'h0, "R1 no oe");
    chk(K_MODE, 0, 8'd0, "R7 plain pin default");
    chk(K_MODE, 1, 8'd1, "R8 code 0 matches alt A");
    chk(K_MODE, 2, 8'd2, "R8 code 0 matches alt B");
    chk(K_MODE, 3, 8'd3, "R8 code 0 gives alt C");
    chk(K_ERR, 0, 8'h0, "R10 valid table");

    // R2 read back and pin mapping
    wr(8'h23, 8'hA5);
    chk(K_RD, 8'h23, 8'hA5, "R2 output byte3");
    chk(K_OUT, 24, 8'h1, "R9 pad_out pin25");
    chk(K_OUT, 25, 8'h0, "R9 pad_out pin26");
    wr(8'h05, 8'h80);
    chk(K_RD, 8'h05, 8'h80, "R2 select byte5");
    chk(K_MODE, 47, 8'd1, "R7 pin48 alt A");
    chk(K_OE, 47, 8'h0, "R9 input pin no oe");

    // R3 direction clears pull
    wr(8'h11, 8'h0F);
    chk(K_RD, 8'h11, 8'h0F, "R2 direction byte1");
    chk(K_RD, 8'h31, 8'hF0, "R3 pull cleared");
    chk(K_RD, 8'h30, 8'hFF, "R3 other pull byte kept");
    wr(8'h31, 8'hFF);
    chk(K_RD, 8'h31, 8'hFF, "R2 pull writable");

    // R9 oe gating by mode
    chk(K_OE, 8, 8'h1, "R9 gpio output oe");
    wr(8'h01, 8'h01);
    chk(K_OE, 8, 8'h0, "R9 alt mode releases pad");
    chk(K_OE, 9, 8'h1, "R9 neighbour oe");

    // R6 level
    wr(8'h21, 8'h02);
    chk(K_LVL, 9, 8'h1, "R6 output level from latch");
    chk(K_LVL, 8, 8'h0, "R6 output level low");

    // R4 synchronizer delay
    @(negedge clk);
    pad_in[12] = 1'b1;
    push(K_LVL, 12, 8'h0, "R4 zero edges");
    @(posedge clk);
    chk(K_LVL, 12, 8'h0, "R4 one edge");
    chk(K_LVL, 12, 8'h1, "R4 two edges");
    chk(K_RD, 8'h41, 8'h10, "R4 input byte1");
    chk(K_LVL, 9, 8'h1, "R6 output ignores pad");

    // R4 / R5 ignored writes
    wr(8'h41, 8'hFF);
    chk(K_RD, 8'h41, 8'h10, "R4 input write ignored");
    wr(8'h06, 8'hFF);
    wr(8'h51, 8'hFF);
    wr(8'h60, 8'hFF);
    chk(K_RD, 8'h06, 8'h00, "R5 unmapped 0x06");
    chk(K_RD, 8'h46, 8'h00, "R5 unmapped 0x46");
    chk(K_RD, 8'h51, 8'h00, "R5 unmapped 0x51");
    chk(K_RD, 8'h60, 8'h00, "R5 unmapped 0x60");
    chk(K_RD, 8'h00, 8'h00, "R5 select untouched");
    chk(K_RD, 8'h50, 8'h00, "R5 alt untouched");

    // R8 alternate decode
    wr(8'h50, 8'h01);
    chk(K_MODE, 1, 8'd2, "R8 pin2 code1 alt B");
    chk(K_MODE, 2, 8'd2, "R8 pin3 code0 alt B");
    chk(K_MODE, 3, 8'd3, "R8 pin4 code0 alt C");
    wr(8'h50, 8'h03);
    chk(K_MODE, 1, 8'd3, "R8 pin2 code3 alt C");
    wr(8'h50, 8'h04);
    chk(K_MODE, 1, 8'd1, "R8 pin2 code0 alt A");
    chk(K_MODE, 2, 8'd1, "R8 pin3 unused msb code1 alt A");
    wr(8'h50, 8'h10);
    chk(K_MODE, 3, 8'd1, "R8 pin4 code2 alt A");
    wr(8'h50, 8'h18);
    chk(K_MODE, 3, 8'd2, "R8 pin4 code3 alt B");
    wr(8'h00, 8'h02);
    chk(K_MODE, 1, 8'd0, "R8 select 1 default");
    chk(K_MODE, 0, 8'd0, "R7 pin1 still default");

    // R9 gpio mode is alt A for pin3
    wr(8'h10, 8'h04);
    chk(K_OE, 2, 8'h0, "R9 pin3 alt B not gpio");
    wr(8'h50, 8'h04);
    chk(K_OE, 2, 8'h1, "R9 pin3 alt A is gpio");
    chk(K_RD, 8'h30, 8'hFB, "R3 pin3 pull cleared");
    wr(8'h20, 8'h04);
    chk(K_OUT, 2, 8'h1, "R9 pad_out pin3");
    chk(K_LVL, 2, 8'h1, "R6 pin3 level");

    // R10 table errors
    chk(K_ERRA, 0, 8'h1, "R10 second without first");
    chk(K_ERRB, 0, 8'h1, "R10 position out of range");

    @(negedge clk);
    #2;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule